// File: doc/BRIEF.md
# Address and data scrambling RAM

This block is a 32-bit, word-addressed memory that sits behind a simple CPU memory port. Internally it is built from four 16-bit single-port banks, grouped into two pairs. The contents and the physical placement of every word are obscured by two key inputs.

On every access, the logical word address is XORed with an address key to choose a physical entry. On a write, the data is XORed with a data key and with the low 16 bits of the logical word address, copied into both halves of the word. A read applies the same mask again, so the original value comes back. Both keys are taken fresh on each access and are never latched. If a key changes, data written earlier is no longer found, or no longer decoded, at its old logical address.

A request is one cycle with `cs` high. `we` gives one enable per byte, and `we` all zero means a read. `ready` and, for reads, `read_data` are valid in the following cycle. The defaults give small banks. Setting `BANK_AW` to 14 gives the full 128 KiB build: four banks of 32 KiB each.

Top module: `scram_ram`

## Requirements
- R1: `ready` is low during reset and in the cycle after any cycle with `cs` low. It is high in the cycle after every cycle in which `cs` is sampled high.
- R2: A full-word write (`we` = 4'b1111) followed by a read of the same logical address, with both keys unchanged, returns the written word.
- R3: `we` bit i enables byte lane `write_data[8i+7:8i]`. Lanes whose bit is clear keep their stored value. An access with `we` = 0 is a read and changes nothing.
- R4: The physical entry is the low `BANK_AW+1` bits of (zero-extended `addr` XOR `addr_key`). Bit `BANK_AW` of that value picks the bank pair. Logical addresses that differ only above that width share one entry, while addresses that differ in bit `BANK_AW` do not.
- R5: The stored word is `write_data ^ data_key ^ {addr[15:0], addr[15:0]}`. A read removes the mask using the current read address, so reading an aliased address returns the data XORed with the duplicated address difference.
- R6: The data key is taken at each access. Reading back with a different data key returns the written data XORed with the old key and the new key.
- R7: The address key is taken at each access. After the key changes, a logical address reads the physical entry selected by the new key, decoded with the read's own address and data key.
- R8: With `cs` held high, accesses complete one per cycle. A read issued in the cycle right after a write to the same address returns the new data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs | input | 1 | Access request for this cycle |
| we | input | DATA_W/8 | Byte write enables; all zero means read |
| addr | input | ADDR_W | Logical word address |
| write_data | input | DATA_W | Write data |
| addr_key | input | DATA_W | Address scrambling key |
| data_key | input | DATA_W | Data scrambling key |
| read_data | output | DATA_W | Read data, valid with `ready` |
| ready | output | 1 | Access completed (one cycle after `cs`) |

## Verification
With `cs` held high, two things can happen in the same cycle: the decoded read data from the previous access is returned while the next access is already writing a bank. The bench provokes this with back-to-back write, read and re-read sequences to one address. It judges each returned word against values worked out from the masking rule. It also changes a key on the exact cycle boundary between a write and its read-back. The expected word is then derived from the old and new keys rather than from the stored data.

// File: rtl/scram_pkg.sv
package scram_pkg;
   // Bank organisation: two pairs, each pair covering one full word.
   localparam int NUM_PAIRS     = 2;
   localparam int BANKS_PER_SET = 2;
   // Key values used by simulation environments after reset.
   localparam logic [31:0] SIM_ADDR_KEY = 32'hDEAD_BEEF;
   localparam logic [31:0] SIM_DATA_KEY = 32'hBD5B_7DDE;
endpackage

// File: rtl/scram_keymix.sv
module scram_keymix #(
   parameter int ADDR_W  = 16,
   parameter int DATA_W  = 32,
   parameter int HALF_W  = 16,
   parameter int PHYS_AW = 9
) (
   input  logic [ADDR_W-1:0]  addr,
   input  logic [DATA_W-1:0]  addr_key,
   input  logic [DATA_W-1:0]  data_key,
   output logic [PHYS_AW-1:0] phys_addr,
   output logic [DATA_W-1:0]  data_mask
);
   localparam int HALVES = DATA_W / HALF_W;

   logic [DATA_W-1:0] addr_ext;
   logic [DATA_W-1:0] addr_mix;
   logic              unused_hi;

   assign addr_ext  = DATA_W'(addr);
   assign addr_mix  = addr_ext ^ addr_key;
   assign phys_addr = addr_mix[PHYS_AW-1:0];
   assign unused_hi = ^addr_mix[DATA_W-1:PHYS_AW];

   // The address tweak repeats the low address bits in every half.
   for (genvar h = 0; h < HALVES; h++) begin : g_half
      assign data_mask[h*HALF_W +: HALF_W] =
         data_key[h*HALF_W +: HALF_W] ^ addr_ext[HALF_W-1:0];
   end
endmodule

// File: rtl/scram_bank.sv
module scram_bank #(
   parameter int WIDTH = 16,
   parameter int AW    = 8
) (
   input  logic               clk,
   input  logic               en,
   input  logic [WIDTH/8-1:0] wbe,
   input  logic [AW-1:0]      addr,
   input  logic [WIDTH-1:0]   wdata,
   output logic [WIDTH-1:0]   rdata
);
   localparam int LANES = WIDTH / 8;
   localparam int DEPTH = 1 << AW;

   logic [WIDTH-1:0] mem [DEPTH];

   // Read-first single port with per-lane write enables.
   always_ff @(posedge clk) begin
      if (en) begin
         rdata <= mem[addr];
         for (int l = 0; l < LANES; l++) begin
            if (wbe[l]) mem[addr][l*8 +: 8] <= wdata[l*8 +: 8];
         end
      end
   end
endmodule

// File: rtl/scram_ram.sv
module scram_ram #(
   parameter int ADDR_W  = 16,
   parameter int DATA_W  = 32,
   parameter int BANK_W  = 16,
   parameter int BANK_AW = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cs,
   input  logic [DATA_W/8-1:0] we,
   input  logic [ADDR_W-1:0]   addr,
   input  logic [DATA_W-1:0]   write_data,
   input  logic [DATA_W-1:0]   addr_key,
   input  logic [DATA_W-1:0]   data_key,
   output logic [DATA_W-1:0]   read_data,
   output logic                ready
);
   import scram_pkg::*;

   localparam int PHYS_AW    = BANK_AW + 1;
   localparam int HALVES     = DATA_W / BANK_W;
   localparam int BANK_LANES = BANK_W / 8;

   // Elaboration-time configuration checks.
   if (HALVES != BANKS_PER_SET || HALVES * BANK_W != DATA_W) begin : g_bad_split
      $error("scram_ram: DATA_W must be exactly two banks wide");
   end
   if (BANK_W % 8 != 0) begin : g_bad_lane
      $error("scram_ram: BANK_W must be a whole number of bytes");
   end
   if (ADDR_W < PHYS_AW || ADDR_W > DATA_W || ADDR_W < BANK_W) begin : g_bad_addr
      $error("scram_ram: ADDR_W out of range for the bank geometry");
   end

   logic [PHYS_AW-1:0] phys_addr;
   logic [DATA_W-1:0]  mask;
   logic [DATA_W-1:0]  wr_word;
   logic               sel_pair;
   logic [BANK_W-1:0]  bank_rdata [NUM_PAIRS][HALVES];

   logic               ready_q;
   logic               pair_q;
   logic [DATA_W-1:0]  mask_q;
   logic [DATA_W-1:0]  read_word;

   scram_keymix #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .HALF_W (BANK_W),
      .PHYS_AW(PHYS_AW)
   ) u_keymix (
      .addr     (addr),
      .addr_key (addr_key),
      .data_key (data_key),
      .phys_addr(phys_addr),
      .data_mask(mask)
   );

   assign wr_word  = write_data ^ mask;
   assign sel_pair = phys_addr[BANK_AW];

   for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
      for (genvar h = 0; h < HALVES; h++) begin : g_bank
         scram_bank #(
            .WIDTH(BANK_W),
            .AW   (BANK_AW)
         ) u_bank (
            .clk  (clk),
            .en   (cs && (sel_pair == 1'(p))),
            .wbe  (we[h*BANK_LANES +: BANK_LANES]),
            .addr (phys_addr[BANK_AW-1:0]),
            .wdata(wr_word[h*BANK_W +: BANK_W]),
            .rdata(bank_rdata[p][h])
         );
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ready_q <= 1'b0;
         pair_q  <= 1'b0;
         mask_q  <= '0;
      end else begin
         ready_q <= cs;
         if (cs) begin
            pair_q <= sel_pair;
            mask_q <= mask;
         end
      end
   end

   always_comb begin
      read_word = '0;
      for (int h = 0; h < HALVES; h++) begin
         read_word[h*BANK_W +: BANK_W] = bank_rdata[pair_q][h];
      end
   end

   assign read_data = read_word ^ mask_q;
   assign ready     = ready_q;
endmodule

// File: rtl/scram_ram_chk.sv
module scram_ram_chk #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 32
) (
   input logic                clk,
   input logic                rst_n,
   input logic                cs,
   input logic [DATA_W/8-1:0] we,
   input logic [ADDR_W-1:0]   addr,
   input logic [DATA_W-1:0]   write_data,
   input logic [DATA_W-1:0]   addr_key,
   input logic [DATA_W-1:0]   data_key,
   input logic [DATA_W-1:0]   read_data,
   input logic                ready
);
   localparam logic [DATA_W/8-1:0] ALL_LANES = '1;

   // R1
   ready_after_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cs |=> ready);

   // R1
   ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cs |=> !ready);

   // R2 R6 R8
   wr_rd_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cs && we == '0 && $past(cs) && $past(we) == ALL_LANES &&
       $past(addr) == addr && $stable(addr_key))
      |=> (read_data == ($past(write_data, 2) ^ $past(data_key, 2) ^ $past(data_key))));

   // R3
   rd_repeat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cs && we == '0 && $past(cs) && $past(we) == '0 && $past(addr) == addr &&
       $stable(addr_key) && $stable(data_key))
      |=> $stable(read_data));
endmodule

bind scram_ram scram_ram_chk #(
   .ADDR_W(ADDR_W),
   .DATA_W(DATA_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cs        (cs),
   .we        (we),
   .addr      (addr),
   .write_data(write_data),
   .addr_key  (addr_key),
   .data_key  (data_key),
   .read_data (read_data),
   .ready     (ready)
);

// File: tb/tb_scram_ram.sv
`timescale 1ns/1ps
module tb_scram_ram;
   import scram_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        cs;
   logic [3:0]  we;
   logic [15:0] addr;
   logic [31:0] write_data;
   logic [31:0] addr_key;
   logic [31:0] data_key;
   logic [31:0] read_data;
   logic        ready;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   scram_ram dut (
      .clk(clk), .rst_n(rst_n), .cs(cs), .we(we), .addr(addr),
      .write_data(write_data), .addr_key(addr_key), .data_key(data_key),
      .read_data(read_data), .ready(ready)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   // One access; cs stays high afterwards so the next access is back-to-back.
   task automatic access(input logic [3:0] w, input logic [15:0] a, input logic [31:0] d,
                         input logic [31:0] exp, input string req);
      cs = 1'b1; we = w; addr = a; write_data = d;
      @(negedge clk);
      check({req, " ready (R1)"}, {31'b0, ready}, 32'd1);
      if (w == 4'b0) check(req, read_data, exp);
   endtask

   task automatic idle();
      cs = 1'b0; we = '0;
      @(negedge clk);
      check("R1 ready low when idle", {31'b0, ready}, 32'd0);
   endtask

   task automatic t_reset();
      rst_n = 1'b0; cs = 1'b0; we = '0; addr = '0; write_data = '0;
      addr_key = SIM_ADDR_KEY; data_key = SIM_DATA_KEY;
      repeat (3) @(negedge clk);
      cs = 1'b1;
      @(negedge clk);
      check("R1 ready low in reset", {31'b0, ready}, 32'd0);
      cs = 1'b0;
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 ready low after reset", {31'b0, ready}, 32'd0);
   endtask

   task automatic t_full_rw();
      access(4'hF, 16'h0000, 32'h0000_0001, '0, "R2");
      access(4'hF, 16'h00FF, 32'hFFFF_FFFF, '0, "R2");
      access(4'hF, 16'h0123, 32'hA5A5_5A5A, '0, "R2");
      access(4'hF, 16'h1234, 32'h8000_0000, '0, "R2");
      idle();
      access(4'h0, 16'h0000, '0, 32'h0000_0001, "R2 addr 0000");
      access(4'h0, 16'h00FF, '0, 32'hFFFF_FFFF, "R2 addr 00FF");
      access(4'h0, 16'h0123, '0, 32'hA5A5_5A5A, "R2 addr 0123");
      access(4'h0, 16'h1234, '0, 32'h8000_0000, "R2 addr 1234");
      idle();
   endtask

   task automatic t_bytes();
      access(4'hF, 16'h0042, 32'h1122_3344, '0, "R3");
      access(4'b0101, 16'h0042, 32'hAABB_CCDD, '0, "R3");
      access(4'h0, 16'h0042, '0, 32'h11BB_33DD, "R3 lanes 0 and 2");
      access(4'b1000, 16'h0042, 32'hEE00_0000, '0, "R3");
      access(4'h0, 16'h0042, 32'hFFFF_FFFF, 32'hEEBB_33DD, "R3 lane 3");
      access(4'h0, 16'h0042, '0, 32'hEEBB_33DD, "R3 read with we zero changes nothing");
      idle();
   endtask

   task automatic t_alias();
      // 0x0010 and 0x0210 differ only above the 9 physical bits.
      access(4'hF, 16'h0010, 32'hCAFE_F00D, '0, "R4");
      access(4'h0, 16'h0210, '0, 32'hC8FE_F20D, "R4 R5 alias read");
      access(4'hF, 16'h0210, 32'h0BAD_BEEF, '0, "R4");
      access(4'h0, 16'h0010, '0, 32'h09AD_BCEF, "R4 R5 alias overwrite");
      // Pair select bit: 0x0030 and 0x0130 are distinct entries.
      access(4'hF, 16'h0030, 32'h1357_9BDF, '0, "R4");
      access(4'hF, 16'h0130, 32'h2468_ACE0, '0, "R4");
      access(4'h0, 16'h0030, '0, 32'h1357_9BDF, "R4 pair 0 entry");
      access(4'h0, 16'h0130, '0, 32'h2468_ACE0, "R4 pair 1 entry");
      idle();
   endtask

   task automatic t_dkey();
      access(4'hF, 16'h0055, 32'h1234_5678, '0, "R6");
      data_key = SIM_DATA_KEY ^ 32'h00FF_0F0F;
      access(4'h0, 16'h0055, '0, 32'h12CB_5977, "R6 new data key");
      data_key = SIM_DATA_KEY;
      access(4'h0, 16'h0055, '0, 32'h1234_5678, "R6 key restored");
      idle();
   endtask

   task automatic t_akey();
      access(4'hF, 16'h0077, 32'h55AA_55AA, '0, "R7");
      access(4'hF, 16'h0177, 32'h0102_0304, '0, "R7");
      idle();
      addr_key = SIM_ADDR_KEY ^ 32'h0000_0100;
      access(4'h0, 16'h0077, '0, 32'h0002_0204, "R7 moved entry x");
      access(4'h0, 16'h0177, '0, 32'h54AA_54AA, "R7 moved entry y");
      addr_key = SIM_ADDR_KEY;
      access(4'h0, 16'h0077, '0, 32'h55AA_55AA, "R7 key restored");
      idle();
   endtask

   task automatic t_b2b();
      access(4'hF, 16'h0005, 32'h0F0F_1234, '0, "R8");
      access(4'h0, 16'h0005, '0, 32'h0F0F_1234, "R8 read right after write");
      access(4'hF, 16'h0005, 32'h7777_0000, '0, "R8");
      access(4'hF, 16'h0006, 32'h0000_8888, '0, "R8");
      access(4'h0, 16'h0005, '0, 32'h7777_0000, "R8 overwrite");
      access(4'h0, 16'h0006, '0, 32'h0000_8888, "R8 neighbour");
      idle();
   endtask

   initial begin
      @(negedge clk);
      t_reset();
      t_full_rw();
      t_bytes();
      t_alias();
      t_dkey();
      t_akey();
      t_b2b();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(4 * 100000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule